// File: doc/BRIEF.md
# Input Change-Detect Interrupt Generator

This block raises an active-low interrupt request when a pin set up as an input no longer matches the value last captured for its port. The pins are split into ports of equal width. Each port keeps a snapshot of its pin levels. The snapshot is taken when reset ends and again each time the register bank pulses that port's read strobe. The pins enter through a synchronizer chain. The comparison uses the raw levels after that chain, with no inversion applied.

Each port has a small tracker state machine with two states. `P_QUIET` means no input-configured pin differs from the snapshot. `P_ALERT` means at least one does. The tracker moves `P_QUIET -> P_ALERT` when an input pin differs and no read strobe is present. It moves `P_ALERT -> P_QUIET` in two cases: the pin reverts, or the port is read. A read also reloads the snapshot.

A global machine sequences start-up. After reset it sits in `G_PRIME` until the synchronizer has filled, loading every snapshot on each of those cycles. It then moves `G_PRIME -> G_ARMED` and stays there until the next reset. The request is high during `G_PRIME`. In `G_ARMED` it is low whenever any port is in `P_ALERT`. The request is meant to drive an open-drain pad enable.

Top module: `chg_irq_top`

## Requirements
- R1: While reset is held and through the priming cycles that follow, `irq_n` is 1. The snapshots load the pin levels present at the end of priming, so pins held steady from reset onward never pull `irq_n` low, whatever their value.
- R2: A pin whose `cfg_dir` bit is 1 (input), with port p owning pin bits [p*8+7:p*8], drives `irq_n` to 0 on the third rising edge after it changes away from its snapshot. `irq_n` is still 1 after the second edge.
- R3: When every differing input pin returns to its snapshot value, `irq_n` returns to 1 on the third rising edge after the revert, with no read needed.
- R4: A one-cycle pulse on `rd_stb[p]` clears port p's pending request at the next rising edge. It also reloads that port's snapshot with the synchronized pin levels, so the new level stops interrupting and a later return to the old level interrupts.
- R5: A read strobe of port 0 leaves a request pending on port 1 in place, and a read strobe of port 1 leaves a request pending on port 0 in place.
- R6: A pin whose `cfg_dir` bit is 0 (output) never causes an interrupt. Turning a pending pin's bit to 0 releases `irq_n` at the next rising edge.
- R7: With both ports pending, `irq_n` stays 0 until the reads of both ports have been made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Pin levels before synchronization; bits [7:0] port 0, [15:8] port 1 |
| cfg_dir | input | 16 | Per-pin direction, 1 = input (watched), 0 = output (ignored) |
| rd_stb | input | 2 | One-cycle read strobe per port, bit p = port p |
| irq_n | output | 1 | Active-low interrupt request, open-drain enable |

## Verification
A pin change reaches `irq_n` through three registers: two synchronizer stages and the tracker state. The result is therefore due on the third rising edge after the change. A read strobe or a direction change acts through the tracker state alone, so its result is due one edge later. Inputs are driven on falling edges and outputs are sampled on falling edges. Every vector waits exactly three edges before its check. The directed latency checks sample both the edge before the expected change and the edge on which it lands. The reset check holds non-zero pins through reset and priming and then confirms that no request appears.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
    typedef enum logic {
        P_QUIET = 1'b0,
        P_ALERT = 1'b1
    } port_state_e;

    typedef enum logic {
        G_PRIME = 1'b0,
        G_ARMED = 1'b1
    } glob_state_e;
endpackage

// File: rtl/chg_irq_sync.sv
module chg_irq_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/chg_irq_port.sv
module chg_irq_port
    import chg_irq_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic [PORT_W-1:0] pin_s,
    input  logic [PORT_W-1:0] cfg,
    input  logic              rd,
    output logic              alert,
    output logic              differ
);
    port_state_e      st_q, st_d;
    logic [PORT_W-1:0] snap_q;

    // masked mismatch against the last captured value
    assign differ = |((pin_s ^ snap_q) & cfg);

    // snapshot register: loads every priming cycle and on each read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              snap_q <= '0;
        else if (!armed || rd)   snap_q <= pin_s;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            P_QUIET: begin
                if (armed && !rd && differ) st_d = P_ALERT;
            end
            P_ALERT: begin
                if (!armed || rd || !differ) st_d = P_QUIET;
            end
            default: st_d = P_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= P_QUIET;
        else        st_q <= st_d;
    end

    // output process
    always_comb begin
        alert = (st_q == P_ALERT);
    end

    p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !rd && differ) |=> (st_q == P_ALERT));

    p_revert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!differ) |=> (st_q == P_QUIET));

    p_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> ((st_q == P_QUIET) && (snap_q == $past(pin_s))));
endmodule

// File: rtl/chg_irq_top.sv
module chg_irq_top
    import chg_irq_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PINS       = NUM_PORTS * PORT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PINS-1:0]      pin_in,
    input  logic [PINS-1:0]      cfg_dir,
    input  logic [NUM_PORTS-1:0] rd_stb,
    output logic                 irq_n
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    glob_state_e           g_q, g_d;
    logic [CNT_W-1:0]      prime_cnt;
    logic [PINS-1:0]       pin_s;
    logic [NUM_PORTS-1:0]  alert_v;
    logic [NUM_PORTS-1:0]  differ_v;
    logic                  armed;

    chg_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (pin_s)
    );

    assign armed = (g_q == G_ARMED);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            chg_irq_port #(.PORT_W(PORT_W)) port_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .armed  (armed),
                .pin_s  (pin_s[p*PORT_W +: PORT_W]),
                .cfg    (cfg_dir[p*PORT_W +: PORT_W]),
                .rd     (rd_stb[p]),
                .alert  (alert_v[p]),
                .differ (differ_v[p])
            );
        end
    endgenerate

    // next-state logic of the start-up machine
    always_comb begin
        g_d = g_q;
        unique case (g_q)
            G_PRIME: if (prime_cnt == CNT_W'(SYNC_STAGES)) g_d = G_ARMED;
            G_ARMED: g_d = G_ARMED;
            default: g_d = G_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q       <= G_PRIME;
            prime_cnt <= '0;
        end else begin
            g_q <= g_d;
            if (g_q == G_PRIME) prime_cnt <= prime_cnt + 1'b1;
        end
    end

    // output process
    always_comb begin
        irq_n = 1'b1;
        unique case (g_q)
            G_PRIME: irq_n = 1'b1;
            G_ARMED: irq_n = ~(|alert_v);
            default: irq_n = 1'b1;
        endcase
    end

    p_prime_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q == G_PRIME) |-> irq_n);

    p_keep_port1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_stb[0] && !rd_stb[1] && differ_v[1]) |=> !irq_n);

    p_keep_port0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_stb[1] && !rd_stb[0] && differ_v[0]) |=> !irq_n);

    p_both_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(alert_v) == 2) |-> !irq_n);
endmodule

// File: tb/chg_irq_top_tb_top.sv
module chg_irq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_in = '0;
    logic [15:0] cfg_dir = 16'hFFFF;
    logic [1:0]  rd_stb = '0;
    logic        irq_n;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    chg_irq_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .cfg_dir (cfg_dir),
        .rd_stb  (rd_stb),
        .irq_n   (irq_n)
    );

    typedef struct packed {
        logic [15:0] pins;
        logic [15:0] cfg;
        logic [1:0]  rd;
        logic        exp_n;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h0001, 16'hFFFF, 2'b00, 1'b0}, // R2 port 0 input changes
        '{16'h0000, 16'hFFFF, 2'b00, 1'b1}, // R3 revert releases
        '{16'h0100, 16'hFFFF, 2'b00, 1'b0}, // R2 port 1 input changes
        '{16'h0100, 16'hFFFF, 2'b01, 1'b0}, // R5 port 0 read keeps port 1
        '{16'h0100, 16'hFFFF, 2'b10, 1'b1}, // R4 port 1 read clears
        '{16'h0000, 16'hFFFF, 2'b00, 1'b0}, // R4 old level now differs
        '{16'h0000, 16'hFFFF, 2'b10, 1'b1}, // R4 read again
        '{16'h0001, 16'hFFFE, 2'b00, 1'b1}, // R6 output pin ignored
        '{16'h8001, 16'hFFFE, 2'b00, 1'b0}, // R2 port 1 bit 7
        '{16'h8001, 16'hFFFE, 2'b10, 1'b1}, // R4 clear port 1
        '{16'h8081, 16'hFFFE, 2'b00, 1'b0}, // R2 port 0 bit 7
        '{16'h8081, 16'hFFFE, 2'b01, 1'b1}, // R4 clear port 0
        '{16'h8081, 16'hFFFF, 2'b00, 1'b1}  // R6 bit 0 back to input, matches
    };

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: irq_n=%b expected %b", req, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] p, input logic [15:0] c, input logic [1:0] r);
        pin_in  = p;
        cfg_dir = c;
        rd_stb  = r;
        @(negedge clk);
        rd_stb  = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: nonzero pins held through reset and priming
        pin_in = 16'h5A5A;
        repeat (3) @(negedge clk);
        check(irq_n, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(irq_n, 1'b1, "R1 priming");
        repeat (6) @(negedge clk);
        check(irq_n, 1'b1, "R1 steady pins after priming");

        // return pins to zero and take a snapshot of both ports
        apply(16'h0000, 16'hFFFF, 2'b00);
        repeat (3) @(negedge clk);
        apply(16'h0000, 16'hFFFF, 2'b11);
        repeat (2) @(negedge clk);
        check(irq_n, 1'b1, "R4 snapshot of zero pins");

        // vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].pins, VECS[i].cfg, VECS[i].rd);
            repeat (2) @(negedge clk);
            check(irq_n, VECS[i].exp_n, $sformatf("vector %0d (R2..R6 table)", i));
        end

        // R2 exact latency: high after two edges, low on the third
        apply(16'h8080, 16'hFFFF, 2'b00);
        @(negedge clk);
        check(irq_n, 1'b1, "R2 not yet after two edges");
        @(negedge clk);
        check(irq_n, 1'b0, "R2 low on third edge");

        // R7: port 0 also pending now (0x80 vs snapshot 0x81); read one port
        apply(16'h8080, 16'hFFFF, 2'b01);
        check(irq_n, 1'b1, "R4 read of port 0 clears one edge later");
        apply(16'h0080, 16'hFFFF, 2'b00);
        apply(16'h0081, 16'hFFFF, 2'b00);
        @(negedge clk);
        check(irq_n, 1'b0, "R7 both ports pending");
        apply(16'h0081, 16'hFFFF, 2'b10);
        check(irq_n, 1'b0, "R7 one read leaves other port");
        apply(16'h0081, 16'hFFFF, 2'b01);
        check(irq_n, 1'b1, "R7 released after both reads");

        // R6: pending pin turned to output releases at the next edge
        apply(16'h0083, 16'hFFFF, 2'b00);
        repeat (2) @(negedge clk);
        check(irq_n, 1'b0, "R6 pending before direction change");
        apply(16'h0083, 16'hFFFD, 2'b00);
        check(irq_n, 1'b1, "R6 output pin released");

        // R3 exact revert latency
        apply(16'h0083, 16'hFFFF, 2'b00);
        @(negedge clk);
        check(irq_n, 1'b0, "R6 input again, pending");
        apply(16'h0081, 16'hFFFF, 2'b00);
        @(negedge clk);
        check(irq_n, 1'b0, "R3 still low after two edges");
        @(negedge clk);
        check(irq_n, 1'b1, "R3 released on third edge");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule